// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Controller

This block sits beside the execute stage of a five-stage, in-order integer pipeline. It works out where each of the two ALU operands should come from. For each operand there are three candidates: the value read from the register file at decode, the ALU result now held in the execute/memory pipeline register, and the writeback value now held in the memory/writeback pipeline register. The block compares the execute-stage source register numbers with the destination numbers carried by the two later stages, then decides. The decision is reported as a 2-bit select code per operand and applied at once by two built-in operand multiplexers.

The block is purely combinational, so its outputs follow its inputs within the same cycle. The later stages are ranked by age: a younger result in the execute/memory stage always wins over an older one in memory/writeback that names the same register. A stage whose write flag is low never supplies a value. Register zero is hardwired, so a write aimed at it is never bypassed. The two operands are resolved independently of each other. The pipeline registers, the ALU, load-use stalls and branch handling belong to the surrounding datapath.

Top module: `fwd_unit`

## Requirements
- R1: Select codes are `00` for the register-file value, `10` for the execute/memory ALU result and `01` for the memory/writeback value. `op_a` and `op_b` always equal the source named by `fwd_a` and `fwd_b`.
- R2: `fwd_a` is `10` whenever `mem_we` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs`.
- R3: `fwd_b` is `10` whenever `mem_we` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rt`.
- R4: An operand's code is `01` when `wb_we` is 1, `wb_rd` is nonzero, `wb_rd` equals that operand's source register, and the condition of R2 (operand A) or R3 (operand B) is false.
- R5: When both later stages name the same nonzero source register with their write flags set, the code is `10` and the operand carries `mem_alu`.
- R6: A stage whose write flag is 0 is never selected, even if its destination matches.
- R7: A destination number of 0 is never selected, even with its write flag set and with a source number of 0.
- R8: Operands A and B are decided independently. In the same cycle one may take `10` and the other `01`, or both may take the same stage.
- R9: Neither select output ever carries `11`. The operand multiplexers treat `11` as the register-file path.
- R10: The outputs are a combinational function of the present inputs and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the execute-stage instruction |
| ex_rt | input | 5 | Second source register number of the execute-stage instruction |
| mem_rd | input | 5 | Destination register number held in the execute/memory register |
| mem_we | input | 1 | Register-write flag held in the execute/memory register |
| wb_rd | input | 5 | Destination register number held in the memory/writeback register |
| wb_we | input | 1 | Register-write flag held in the memory/writeback register |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| mem_alu | input | 32 | ALU result held in the execute/memory register |
| wb_val | input | 32 | Writeback value held in the memory/writeback register |
| fwd_a | output | 2 | Select code for operand A |
| fwd_b | output | 2 | Select code for operand B |
| op_a | output | 32 | Resolved operand A |
| op_b | output | 32 | Resolved operand B |

## Verification
The bench focuses on the double-hazard case, where both later stages target the same register. A design that ranks the stages the wrong way would hand the ALU the stale writeback value. It also drives matching destinations with the write flag cleared, and writes aimed at register zero while the source is zero. A design that skipped either gate would bypass a value that no instruction ever committed. Split cases, where A hits one stage and B the other, expose any coupling between the operand lanes. A sweep over register numbers with all write-flag combinations catches a swapped select encoding or a mux that routes the wrong source.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source codes; the bit pattern is what the datapath decodes.
   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_WB  = 2'b01,
      SRC_MEM = 2'b10,
      SRC_RSV = 2'b11
   } fwd_src_e;

   localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/fwd_hit.sv
// Decides whether one later stage holds the register one operand needs.
module fwd_hit #(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_reg,
   input  logic [REG_AW-1:0] dst_reg,
   input  logic              dst_we,
   output logic              hit
);

   logic same;
   assign same = (dst_reg == src_reg);

   generate
      if (ZERO_GUARD) begin : g_zero_hard
         logic dst_live;
         assign dst_live = |dst_reg;
         assign hit = dst_we & dst_live & same;
      end else begin : g_zero_soft
         assign hit = dst_we & same;
      end
   endgenerate

endmodule

// File: rtl/fwd_prio.sv
// Ranks the two later stages: the younger result wins.
module fwd_prio
   import fwd_pkg::*;
(
   input  logic     hit_mem,
   input  logic     hit_wb,
   output fwd_src_e sel
);

   always_comb begin
      if (hit_mem)     sel = SRC_MEM;
      else if (hit_wb) sel = SRC_WB;
      else             sel = SRC_RF;
   end

endmodule

// File: rtl/fwd_opmux.sv
// Three-way operand selector; the reserved code falls back to the register file.
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_src_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] op_val
);

   always_comb begin
      unique case (sel)
         SRC_MEM: op_val = mem_val;
         SRC_WB:  op_val = wb_val;
         SRC_RF,
         SRC_RSV: op_val = rf_val;
         default: op_val = rf_val;
      endcase
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter int unsigned DATA_W     = 32,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] ex_rs,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_we,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_we,
   input  logic [DATA_W-1:0] rf_a,
   input  logic [DATA_W-1:0] rf_b,
   input  logic [DATA_W-1:0] mem_alu,
   input  logic [DATA_W-1:0] wb_val,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b
);

   localparam int unsigned OPS = NUM_OPS;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("fwd_unit: REG_AW must lie in 1..8");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("fwd_unit: DATA_W must be positive");
      end
   endgenerate

   logic [REG_AW-1:0] src_reg [OPS];
   logic [DATA_W-1:0] rf_val  [OPS];
   logic [DATA_W-1:0] op_val  [OPS];
   fwd_src_e          sel     [OPS];

   assign src_reg[0] = ex_rs;
   assign src_reg[1] = ex_rt;
   assign rf_val[0]  = rf_a;
   assign rf_val[1]  = rf_b;

   generate
      for (genvar op = 0; op < OPS; op++) begin : g_lane
         logic hit_mem;
         logic hit_wb;

         fwd_hit #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_hit_mem (
            .src_reg (src_reg[op]),
            .dst_reg (mem_rd),
            .dst_we  (mem_we),
            .hit     (hit_mem)
         );

         fwd_hit #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_hit_wb (
            .src_reg (src_reg[op]),
            .dst_reg (wb_rd),
            .dst_we  (wb_we),
            .hit     (hit_wb)
         );

         fwd_prio u_prio (
            .hit_mem (hit_mem),
            .hit_wb  (hit_wb),
            .sel     (sel[op])
         );

         fwd_opmux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel[op]),
            .rf_val  (rf_val[op]),
            .mem_val (mem_alu),
            .wb_val  (wb_val),
            .op_val  (op_val[op])
         );
      end
   endgenerate

   assign fwd_a = sel[0];
   assign fwd_b = sel[1];
   assign op_a  = op_val[0];
   assign op_b  = op_val[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned DATA_W = 32
) (
   input logic [REG_AW-1:0] ex_rs,
   input logic [REG_AW-1:0] ex_rt,
   input logic [REG_AW-1:0] mem_rd,
   input logic              mem_we,
   input logic [REG_AW-1:0] wb_rd,
   input logic              wb_we,
   input logic [DATA_W-1:0] rf_a,
   input logic [DATA_W-1:0] rf_b,
   input logic [DATA_W-1:0] mem_alu,
   input logic [DATA_W-1:0] wb_val,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b
);

   logic known;
   assign known = !$isunknown({ex_rs, ex_rt, mem_rd, mem_we, wb_rd, wb_we,
                               rf_a, rf_b, mem_alu, wb_val, fwd_a, fwd_b});

   always_comb begin
      if (known) begin
         // R9
         sel_legal_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
         // R1
         opa_route_chk: assert (op_a == (fwd_a == 2'b10 ? mem_alu :
                                         fwd_a == 2'b01 ? wb_val : rf_a));
         // R1
         opb_route_chk: assert (op_b == (fwd_b == 2'b10 ? mem_alu :
                                         fwd_b == 2'b01 ? wb_val : rf_b));
         // R2
         a_mem_chk: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rs) || fwd_a == 2'b10);
         // R3
         b_mem_chk: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rt) || fwd_b == 2'b10);
         // R6
         a_mem_gate_chk: assert (fwd_a != 2'b10 || (mem_we && mem_rd == ex_rs));
         // R7
         a_wb_zero_chk: assert (fwd_a != 2'b01 || (wb_we && wb_rd != '0 && wb_rd == ex_rs));
         // R4
         b_wb_chk: assert (fwd_b != 2'b01 || (wb_we && wb_rd != '0 && wb_rd == ex_rt));
      end
   end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) chk_i (
   .ex_rs   (ex_rs),
   .ex_rt   (ex_rt),
   .mem_rd  (mem_rd),
   .mem_we  (mem_we),
   .wb_rd   (wb_rd),
   .wb_we   (wb_we),
   .rf_a    (rf_a),
   .rf_b    (rf_b),
   .mem_alu (mem_alu),
   .wb_val  (wb_val),
   .fwd_a   (fwd_a),
   .fwd_b   (fwd_b),
   .op_a    (op_a),
   .op_b    (op_b)
);

// File: tb/fwd_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_unit_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [4:0]  ex_rs, ex_rt, mem_rd, wb_rd;
   logic        mem_we, wb_we;
   logic [31:0] rf_a, rf_b, mem_alu, wb_val;
   logic [1:0]  fwd_a, fwd_b;
   logic [31:0] op_a, op_b;

   int checks = 0;
   int errors = 0;

   fwd_unit dut_i (
      .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_rd(mem_rd), .mem_we(mem_we),
      .wb_rd(wb_rd), .wb_we(wb_we), .rf_a(rf_a), .rf_b(rf_b),
      .mem_alu(mem_alu), .wb_val(wb_val), .fwd_a(fwd_a), .fwd_b(fwd_b),
      .op_a(op_a), .op_b(op_b)
   );

   // Select expected from the requirements: 10 wins over 01, both gated by flag and nonzero.
   function automatic logic [1:0] want_sel(logic [4:0] s, logic [4:0] md, logic mw,
                                           logic [4:0] wd, logic ww);
      if (mw && md != 5'd0 && md == s) return 2'b10;
      if (ww && wd != 5'd0 && wd == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [31:0] want_op(logic [1:0] c, logic [31:0] rf);
      return (c == 2'b10) ? mem_alu : (c == 2'b01) ? wb_val : rf;
   endfunction

   task automatic drive(logic [4:0] rs, logic [4:0] rt, logic [4:0] md, logic mw,
                        logic [4:0] wd, logic ww);
      @(negedge clk);
      ex_rs = rs; ex_rt = rt; mem_rd = md; mem_we = mw; wb_rd = wd; wb_we = ww;
      #1;
   endtask

   task automatic check_sel(string tag, logic [1:0] ea, logic [1:0] eb);
      checks++;
      if (fwd_a !== ea || fwd_b !== eb || op_a !== want_op(ea, rf_a) || op_b !== want_op(eb, rf_b)) begin
         errors++;
         $display("FAIL %s: fwd_a=%b fwd_b=%b op_a=%h op_b=%h expected %b %b %h %h",
                  tag, fwd_a, fwd_b, op_a, op_b, ea, eb, want_op(ea, rf_a), want_op(eb, rf_b));
      end
   endtask

   task automatic t_reset_idle();
      drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
      check_sel("R1 idle register-file path", 2'b00, 2'b00);
      drive(5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1);
      check_sel("R1 no match", 2'b00, 2'b00);
   endtask

   task automatic t_ex_hit_a();
      drive(5'd5, 5'd6, 5'd5, 1'b1, 5'd0, 1'b0);
      check_sel("R2 operand A from EX/MEM", 2'b10, 2'b00);
   endtask

   task automatic t_ex_hit_b();
      drive(5'd9, 5'd12, 5'd12, 1'b1, 5'd0, 1'b0);
      check_sel("R3 operand B from EX/MEM", 2'b00, 2'b10);
   endtask

   task automatic t_wb_hit();
      drive(5'd17, 5'd18, 5'd1, 1'b1, 5'd17, 1'b1);
      check_sel("R4 operand A from MEM/WB", 2'b01, 2'b00);
      drive(5'd2, 5'd31, 5'd0, 1'b0, 5'd31, 1'b1);
      check_sel("R4 operand B from MEM/WB", 2'b00, 2'b01);
   endtask

   task automatic t_priority();
      drive(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);
      check_sel("R5 younger stage wins both", 2'b10, 2'b10);
      drive(5'd1, 5'd1, 5'd1, 1'b0, 5'd1, 1'b1);
      check_sel("R5 older used when younger silent", 2'b01, 2'b01);
   endtask

   task automatic t_no_write();
      drive(5'd10, 5'd11, 5'd10, 1'b0, 5'd11, 1'b0);
      check_sel("R6 write flags low", 2'b00, 2'b00);
   endtask

   task automatic t_zero_dst();
      drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
      check_sel("R7 register zero never bypassed", 2'b00, 2'b00);
      drive(5'd0, 5'd4, 5'd0, 1'b1, 5'd4, 1'b1);
      check_sel("R7 zero on A while B bypasses", 2'b00, 2'b01);
   endtask

   task automatic t_split();
      drive(5'd20, 5'd21, 5'd20, 1'b1, 5'd21, 1'b1);
      check_sel("R8 A from EX/MEM B from MEM/WB", 2'b10, 2'b01);
      drive(5'd21, 5'd20, 5'd20, 1'b1, 5'd21, 1'b1);
      check_sel("R8 A from MEM/WB B from EX/MEM", 2'b01, 2'b10);
   endtask

   task automatic t_sweep();
      for (int rs = 0; rs < 8; rs++)
         for (int md = 0; md < 8; md++)
            for (int wd = 0; wd < 8; wd++)
               for (int fl = 0; fl < 4; fl++) begin
                  drive(rs[4:0], 5'(7 - rs), md[4:0], fl[0], wd[4:0], fl[1]);
                  check_sel("R9 R10 sweep",
                            want_sel(rs[4:0], md[4:0], fl[0], wd[4:0], fl[1]),
                            want_sel(5'(7 - rs), md[4:0], fl[0], wd[4:0], fl[1]));
                  if (fwd_a == 2'b11 || fwd_b == 2'b11) begin
                     errors++;
                     $display("FAIL R9: reserved code seen a=%b b=%b expected not 11", fwd_a, fwd_b);
                  end
               end
   endtask

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      ex_rs = '0; ex_rt = '0; mem_rd = '0; wb_rd = '0; mem_we = 1'b0; wb_we = 1'b0;
      rf_a = 32'hA1A1_0001; rf_b = 32'hB2B2_0002;
      mem_alu = 32'hC3C3_0003; wb_val = 32'hD4D4_0004;
      repeat (3) @(posedge clk);
      #1;
      check_sel("R1 reset state", 2'b00, 2'b00);
      rst_n = 1'b1;
      t_reset_idle();
      t_ex_hit_a();
      t_ex_hit_b();
      t_wb_hit();
      t_priority();
      t_no_write();
      t_zero_dst();
      t_split();
      // R10: changing only data inputs moves the operands in the same cycle
      drive(5'd5, 5'd6, 5'd5, 1'b1, 5'd6, 1'b1);
      mem_alu = 32'h1234_5678; wb_val = 32'h8765_4321;
      #1;
      check_sel("R10 same-cycle data follow", 2'b10, 2'b01);
      t_sweep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule